// File: doc/BRIEF.md
# Angle-to-PWM Delta-Sigma Encoder

This block turns an angle word into a single-bit pulse-density stream whose long-run share of high bits is proportional to the angle. A first-order delta-sigma modulator produces the stream: each modulator tick adds the angle to an accumulator, and the carry out of that addition becomes the next output bit. The stream leaves the block as a complementary pair (`pwm_p_o` and `pwm_n_o`). A downstream analog or digital low-pass filter recovers the angle from it.

The modulator rate comes from a clock-enable divider on the system clock, with a programmable ratio. A new angle is taken in only at a tick, so the value added within one tick never changes. Two mappings are available.

- **Wrapping:** the low 16 bits of a multi-turn angle are used, so the duty cycle rolls from near 100 % back to 0 % at every full turn.
- **Clamped:** the angle is read as a signed multi-turn value, and anything outside one turn pins the output low or high.

A sample pulse and a frame strobe mark every tick and every 2^N ticks. A downstream decimation filter uses them to sample the stream in step with the modulator. The index input passes straight to its output.

Top module: `angle_dsm_pwm`

## Requirements
- R1: At each tick the accumulator (16 bits, cleared by reset) takes the sum of itself and the low 16 bits of the selected angle. The carry out of that sum becomes the new output bit.
- R2: With a constant in-range angle `a`, every run of 2^k ticks (2^k a multiple of 65536/gcd) holds exactly a·2^k/65536 high bits. In particular, angle 0 gives no high bit, 0x4000 gives 1 in every 4, and 0x0100 gives 1 in every 256.
- R3: With `clamp_i`=0 (wrapping), only bits [15:0] of `ang_i` matter. For example, 0x014000 behaves like 0x4000.
- R4: With `clamp_i`=1, `ang_i` is signed 24 bits. A negative value makes every output bit 0, a value ≥ 0x10000 makes every output bit 1, and either case leaves the accumulator unchanged. Values 0..0xFFFF behave as in R1.
- R5: `pwm_n_o` is always the inverse of `pwm_p_o`.
- R6: `idx_o` equals `idx_i` at all times, in any mode.
- R7: `sclk_o` is high for one cycle in the clock after each tick, and `pwm_p_o` changes only in a cycle where `sclk_o` is high.
- R8: Ticks occur once every `div_i` clock cycles. A `div_i` of 0 acts as 1, which gives a tick every cycle.
- R9: Tick indices count from 0 after reset. `frame_o` is high together with `sclk_o` for tick index k·2^N−1, where N is `frm_log_i` clamped to the range 4..12.
- R10: `ang_i` is captured at a tick only when `ang_vld_i` is high; otherwise the last captured angle (0 after reset) is used.
- R11: A synchronous reset gives `pwm_p_o`=0, `pwm_n_o`=1, `sclk_o`=0 and `frame_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ang_i | input | 24 | Multi-turn angle, low 16 bits are one turn |
| ang_vld_i | input | 1 | Angle valid, sampled at ticks |
| clamp_i | input | 1 | 1 = clamped mapping, 0 = wrapping |
| div_i | input | 16 | Clock cycles per modulator tick (0 = 1) |
| frm_log_i | input | 4 | Frame length exponent N |
| idx_i | input | 1 | Index pulse in |
| pwm_p_o | output | 1 | Modulator output bit |
| pwm_n_o | output | 1 | Complement of the output bit |
| idx_o | output | 1 | Index pulse out |
| sclk_o | output | 1 | Sample pulse, one per tick |
| frame_o | output | 1 | Frame strobe, last tick of each frame |

## Verification
The bench builds the block with its default parameters: a 16-bit turn, a 24-bit multi-turn input, a 16-bit divider and frame exponents from 4 to 12. These defaults allow short windows of 32 to 256 ticks in which exact high-bit counts are known for angles such as 0x0100, 0x4000 and 0x8000. With a divider ratio of 1, long runs fit in a few thousand cycles. The 24-bit input leaves room for negative values and values past one turn, so both clamp limits and wrap aliasing can be exercised. Small frame exponents, including the out-of-range values 3 and 15, show frame boundaries within 64 ticks.

// File: rtl/angle_pwm_pkg.sv
package angle_pwm_pkg;
    localparam int TURN_BITS  = 16;
    localparam int MULTI_BITS = 24;
    localparam int RATIO_BITS = 16;
    localparam int LOG_LO     = 4;
    localparam int LOG_HI     = 12;

    typedef enum logic {MAP_WRAP = 1'b0, MAP_CLAMP = 1'b1} map_mode_e;
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
    parameter int RATIO_W = angle_pwm_pkg::RATIO_BITS
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               tick_o
);
    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic               tick;
    } div_state_t;

    div_state_t st_d, st_q;
    logic [RATIO_W-1:0] ratio_eff;
    logic               wrap;

    always_comb begin
        ratio_eff = (ratio_i == '0) ? RATIO_W'(1) : ratio_i;
        wrap      = (st_q.cnt >= ratio_eff - RATIO_W'(1));
        st_d      = st_q;
        st_d.tick = wrap;
        st_d.cnt  = wrap ? '0 : st_q.cnt + RATIO_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R8: with a ratio above one, a tick never repeats in the next cycle
    assert_tick_spacing_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.tick && ratio_i > RATIO_W'(1)) |=> !st_q.tick);
endmodule

// File: rtl/frame_marker.sv
module frame_marker #(
    parameter int LOG_MIN = angle_pwm_pkg::LOG_LO,
    parameter int LOG_MAX = angle_pwm_pkg::LOG_HI,
    parameter int LOG_W   = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             tick_i,
    input  logic [LOG_W-1:0] log_i,
    output logic             sclk_o,
    output logic             frame_o
);
    typedef struct packed {
        logic [LOG_MAX-1:0] cnt;
        logic               sclk;
        logic               frame;
    } frm_state_t;

    frm_state_t         st_d, st_q;
    logic [LOG_W-1:0]   n_eff;
    logic [LOG_MAX-1:0] mask;

    always_comb begin
        if (log_i < LOG_W'(LOG_MIN))      n_eff = LOG_W'(LOG_MIN);
        else if (log_i > LOG_W'(LOG_MAX)) n_eff = LOG_W'(LOG_MAX);
        else                              n_eff = log_i;
        mask       = ~({LOG_MAX{1'b1}} << n_eff);
        st_d       = st_q;
        st_d.sclk  = tick_i;
        st_d.frame = tick_i && ((st_q.cnt & mask) == mask);
        if (tick_i) st_d.cnt = st_q.cnt + LOG_MAX'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign sclk_o  = st_q.sclk;
    assign frame_o = st_q.frame;

    // R7: the sample pulse lasts exactly one cycle after each tick
    assert_sclk_follows_tick_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        tick_i |=> st_q.sclk);
endmodule

// File: rtl/dsm_core.sv
module dsm_core #(
    parameter int ANG_W  = angle_pwm_pkg::TURN_BITS,
    parameter int TURN_W = angle_pwm_pkg::MULTI_BITS
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic [TURN_W-1:0] ang_i,
    input  logic              vld_i,
    input  logic              clamp_i,
    output logic              bit_o
);
    typedef struct packed {
        logic [ANG_W-1:0]  acc;
        logic [TURN_W-1:0] ang;
        logic              bit_v;
    } dsm_state_t;

    dsm_state_t         st_d, st_q;
    logic [TURN_W-1:0]  sel;
    logic               neg, over;
    logic [ANG_W:0]     sum;

    always_comb begin
        sel  = vld_i ? ang_i : st_q.ang;
        neg  = sel[TURN_W-1];
        over = !neg && (|sel[TURN_W-2:ANG_W]);
        sum  = {1'b0, st_q.acc} + {1'b0, sel[ANG_W-1:0]};
        st_d = st_q;
        if (tick_i) begin
            st_d.ang = sel;
            if (clamp_i == angle_pwm_pkg::MAP_CLAMP && neg) begin
                st_d.bit_v = 1'b0;
            end else if (clamp_i == angle_pwm_pkg::MAP_CLAMP && over) begin
                st_d.bit_v = 1'b1;
            end else begin
                st_d.acc   = sum[ANG_W-1:0];
                st_d.bit_v = sum[ANG_W];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) st_q <= '0;
        else       st_q <= st_d;
    end

    assign bit_o = st_q.bit_v;

    // R4: clamped negative angle forces a low bit
    assert_clamp_low_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && clamp_i && neg) |=> !st_q.bit_v);
    // R4: clamped angle past one turn forces a high bit
    assert_clamp_high_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && clamp_i && over) |=> st_q.bit_v);
    // R2: zero angle from a zero-carry step yields a low bit in wrap mode
    assert_zero_angle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !clamp_i && sel[ANG_W-1:0] == '0) |=> !st_q.bit_v);
endmodule

// File: rtl/angle_dsm_pwm.sv
module angle_dsm_pwm #(
    parameter int ANG_W   = angle_pwm_pkg::TURN_BITS,
    parameter int TURN_W  = angle_pwm_pkg::MULTI_BITS,
    parameter int RATIO_W = angle_pwm_pkg::RATIO_BITS,
    parameter int LOG_MIN = angle_pwm_pkg::LOG_LO,
    parameter int LOG_MAX = angle_pwm_pkg::LOG_HI,
    parameter int LOG_W   = 4
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [TURN_W-1:0]  ang_i,
    input  logic               ang_vld_i,
    input  logic               clamp_i,
    input  logic [RATIO_W-1:0] div_i,
    input  logic [LOG_W-1:0]   frm_log_i,
    input  logic               idx_i,
    output logic               pwm_p_o,
    output logic               pwm_n_o,
    output logic               idx_o,
    output logic               sclk_o,
    output logic               frame_o
);
    logic tick;
    logic bit_w;

    tick_divider #(.RATIO_W(RATIO_W)) u_div (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ratio_i (div_i),
        .tick_o  (tick)
    );

    dsm_core #(.ANG_W(ANG_W), .TURN_W(TURN_W)) u_dsm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick),
        .ang_i   (ang_i),
        .vld_i   (ang_vld_i),
        .clamp_i (clamp_i),
        .bit_o   (bit_w)
    );

    frame_marker #(.LOG_MIN(LOG_MIN), .LOG_MAX(LOG_MAX), .LOG_W(LOG_W)) u_frm (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .tick_i  (tick),
        .log_i   (frm_log_i),
        .sclk_o  (sclk_o),
        .frame_o (frame_o)
    );

    assign pwm_p_o = bit_w;
    assign pwm_n_o = ~bit_w;
    assign idx_o   = idx_i;

    // R7: the output bit moves only alongside a sample pulse
    assert_change_on_sclk_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(pwm_p_o) |-> sclk_o);
    // R9: a frame strobe always coincides with a sample pulse
    assert_frame_on_sclk_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_o |-> sclk_o);
endmodule

// File: tb/tb_angle_dsm_pwm.sv
`timescale 1ns/1ps
module tb_angle_dsm_pwm;
    logic        clk = 1'b0;
    logic        rst;
    logic [23:0] ang;
    logic        vld;
    logic        clamp;
    logic [15:0] div;
    logic [3:0]  flog;
    logic        idx;
    logic        pwm_p, pwm_n, idx_o, sclk, frame;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    angle_dsm_pwm dut (
        .clk_i(clk), .rst_i(rst), .ang_i(ang), .ang_vld_i(vld), .clamp_i(clamp),
        .div_i(div), .frm_log_i(flog), .idx_i(idx), .pwm_p_o(pwm_p),
        .pwm_n_o(pwm_n), .idx_o(idx_o), .sclk_o(sclk), .frame_o(frame)
    );

    // behavioural reference model
    int m_cnt, m_acc, m_ang, m_fc;
    bit m_tick, m_pwm, m_sclk, m_frame;

    always @(posedge clk) begin
        int r, a, s, n, msk;
        bit nb, nt;
        if (rst) begin
            m_cnt = 0; m_acc = 0; m_ang = 0; m_fc = 0;
            m_tick = 0; m_pwm = 0; m_sclk = 0; m_frame = 0;
        end else begin
            r = (div == 0) ? 1 : int'(div);
            n = (flog < 4) ? 4 : ((flog > 12) ? 12 : int'(flog));
            msk = (1 << n) - 1;
            nb = m_pwm;
            if (m_tick) begin
                a = vld ? int'($signed(ang)) : m_ang;
                m_ang = a;
                if (clamp && a < 0) nb = 0;
                else if (clamp && a >= 65536) nb = 1;
                else begin
                    s = m_acc + (a & 16'hFFFF);
                    nb = (s >= 65536);
                    m_acc = s % 65536;
                end
            end
            m_pwm = nb;
            m_frame = m_tick && ((m_fc & msk) == msk);
            m_sclk = m_tick;
            if (m_tick) m_fc = (m_fc + 1) % 4096;
            nt = (m_cnt >= r - 1);
            m_cnt = nt ? 0 : m_cnt + 1;
            m_tick = nt;
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (pwm_p !== m_pwm || sclk !== m_sclk || frame !== m_frame) begin
                errors++;
                $display("FAIL R1/R7/R9 model: p=%0b s=%0b f=%0b exp p=%0b s=%0b f=%0b",
                         pwm_p, sclk, frame, m_pwm, m_sclk, m_frame);
            end
            checks++;
            if (pwm_n !== ~pwm_p) begin
                errors++;
                $display("FAIL R5: n=%0b exp %0b", pwm_n, ~pwm_p);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic measure(input int nt, output int ones, output int frames);
        int t = 0;
        ones = 0; frames = 0;
        while (t < nt) begin
            @(negedge clk);
            if (sclk) begin
                t++;
                ones += pwm_p;
                frames += frame;
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic settle();
        int o, f;
        measure(3, o, f);
    endtask

    initial begin
        int o, f, c;
        rst = 1'b1; ang = '0; vld = 1'b0; clamp = 1'b0; div = 16'd1;
        flog = 4'd4; idx = 1'b0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 p", pwm_p, 0); check("R11 n", pwm_n, 1);
        check("R11 sclk", sclk, 0); check("R11 frame", frame, 0);
        rst = 1'b0;

        // R9 frames from reset, N=4 -> 4 frames in 64 ticks
        measure(64, o, f); check("R9 N=4", f, 4);
        flog = 4'd3; do_reset(); measure(64, o, f); check("R9 N=3 clamps to 4", f, 4);
        flog = 4'd5; do_reset(); measure(64, o, f); check("R9 N=5", f, 2);
        flog = 4'd15; do_reset(); measure(64, o, f); check("R9 N=15 clamps to 12", f, 0);
        check("R2 zero angle", o, 0);

        // R1/R2 wrap mode duty
        vld = 1'b1; ang = 24'h004000; settle(); measure(256, o, f);
        check("R2 0x4000", o, 64);
        ang = 24'h000100; settle(); measure(256, o, f); check("R2 0x0100", o, 1);
        ang = 24'h008000; settle(); measure(32, o, f); check("R1 0x8000", o, 16);
        ang = 24'h00FFFF; settle(); measure(256, o, f);
        check("R1 0xFFFF near full", (o >= 255) ? 1 : 0, 1);
        // R3 wrap uses low bits only
        ang = 24'h014000; settle(); measure(32, o, f); check("R3 0x014000", o, 8);
        ang = 24'hFFC000; settle(); measure(32, o, f); check("R3 negative wraps", o, 24);

        // R4 clamped mode
        clamp = 1'b1;
        ang = 24'hFFFFFB; settle(); measure(32, o, f); check("R4 negative", o, 0);
        ang = 24'h012345; settle(); measure(32, o, f); check("R4 over turn", o, 32);
        ang = 24'h008000; settle(); measure(32, o, f); check("R4 in range", o, 16);
        clamp = 1'b0;

        // R10 hold when not valid
        ang = 24'h004000; settle(); vld = 1'b0; ang = 24'h000000;
        measure(32, o, f); check("R10 hold", o, 8);
        vld = 1'b1; ang = 24'h000000; settle(); measure(32, o, f); check("R10 new", o, 0);

        // R8 divider
        div = 16'd5; ang = 24'h004000; settle();
        c = 0; o = 0;
        while (o < 10) begin @(negedge clk); c++; if (sclk) o++; end
        check("R8 ratio 5", c, 50);
        div = 16'd0; settle();
        c = 0; o = 0;
        while (o < 10) begin @(negedge clk); c++; if (sclk) o++; end
        check("R8 ratio 0", c, 10);

        // R6 index passthrough
        idx = 1'b1; #1; check("R6 high", idx_o, 1);
        clamp = 1'b1; #1; check("R6 clamp", idx_o, 1);
        idx = 1'b0; #1; check("R6 low", idx_o, 0);

        @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule